// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A walk starts from a root frame number, which places the first-level table on a 4 KB boundary. The walker reads one first-level entry, and that entry names the 4 KB frame holding a second-level table. It then reads one second-level entry, which names the physical frame of the target 4 KB page. A walk produces either a physical address or a fault that reports the level where the walk stopped. The last entry read is returned so that a TLB can be filled from it.

The walker uses a simple read port with no backpressure. A request is held until a response-valid strobe arrives, however many cycles that takes. The walker runs one walk at a time. The states are idle, first read, second read and a single done cycle, and a new walk is taken only in the idle state.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into a first-level index in bits [31:22], a second-level index in bits [21:12] and a page offset in bits [11:0].
- R2: The first-level entry is read at byte address {root_frame, 12'h000} + 4 x first-level index, and every read address is a multiple of 4.
- R3: Every entry is 32 bits wide. Bit 0 is the valid flag, bits [31:12] hold a frame number and bits [11:1] are ignored. The second-level entry is read at {first-level frame, 12'h000} + 4 x second-level index.
- R4: On success, done_paddr = {second-level frame, virtual offset}, done_entry is the second-level entry and done_fault is 0.
- R5: A successful walk issues exactly two reads: the first-level read, then the second-level read.
- R6: If the first-level entry is invalid, the walk ends with done_fault = 1 and done_level = 0. No second read is issued, done_entry holds the first-level entry and done_paddr is 0.
- R7: If the second-level entry is invalid, the walk ends with done_fault = 1, done_level = 1 and done_paddr = 0, and done_entry holds the second-level entry.
- R8: walk_ready is high only while idle. A walk_start seen while busy is ignored and does not change the walk in progress.
- R9: mem_rd_valid stays high with a stable mem_rd_addr until mem_rsp_valid is sampled, for any response latency including a response in the first request cycle.
- R10: done_valid is a one-cycle pulse in the cycle after the final response is sampled, and walk_ready is high again in the next cycle.
- R11: After reset, walk_ready is 1 and both mem_rd_valid and done_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| walk_start | input | 1 | Starts a walk when walk_ready is high |
| walk_vaddr | input | 32 | Virtual address to translate, sampled with walk_start |
| root_frame | input | 20 | Frame number of the first-level table, sampled with walk_start |
| walk_ready | output | 1 | High while idle |
| mem_rd_valid | output | 1 | Memory read request, held until answered |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid strobe |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | One-cycle walk completion strobe |
| done_fault | output | 1 | Walk ended on an invalid entry |
| done_level | output | 1 | Level of the fault: 0 first, 1 second |
| done_paddr | output | 32 | Translated physical address, 0 on fault |
| done_entry | output | 32 | Last entry read, for a TLB fill |

## Verification
The embedded properties assume that the memory raises mem_rsp_valid only while a request is outstanding, and for one cycle per request. They also assume that root_frame and walk_vaddr are sampled only together with an accepted walk_start. The bench memory model follows these rules. It answers each outstanding read once after a programmed latency of zero to three cycles and then drops the strobe. Entry contents are computed from the address alone, so every walk outcome can be predicted arithmetically. The sweep covers the extreme and intermediate indices at both levels and reaches faults at each level. Some walks hold walk_start high with a different address throughout, to show that a start request is ignored while busy.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_RD1  = 2'd1,
    WS_RD2  = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;

endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int PTE_W = 32
) (
  input  logic [VA_W-1:0]        vaddr,
  input  logic [PTE_W-OFS_W-1:0] root_frame,
  input  logic [PTE_W-OFS_W-1:0] l1_frame,
  input  logic [PTE_W-OFS_W-1:0] l2_frame,
  input  logic                   sel_l2,
  output logic [PTE_W-1:0]       rd_addr,
  output logic [PTE_W-1:0]       paddr
);

  localparam int PA_W = PTE_W;
  localparam int L2_LO = OFS_W;
  localparam int L1_LO = OFS_W + L2_W;

  logic [L1_W-1:0]  idx1;
  logic [L2_W-1:0]  idx2;
  logic [OFS_W-1:0] ofs;
  logic [PA_W-1:0]  l1_addr;
  logic [PA_W-1:0]  l2_addr;

  // R1: field split of the virtual address
  assign idx1 = vaddr[L1_LO +: L1_W];
  assign idx2 = vaddr[L2_LO +: L2_W];
  assign ofs  = vaddr[OFS_W-1:0];

  // R2, R3: table base plus index scaled by the 4-byte entry size
  assign l1_addr = {root_frame, {OFS_W{1'b0}}}
                 + {{(PA_W-L1_W-2){1'b0}}, idx1, 2'b00};
  assign l2_addr = {l1_frame, {OFS_W{1'b0}}}
                 + {{(PA_W-L2_W-2){1'b0}}, idx2, 2'b00};

  assign rd_addr = sel_l2 ? l2_addr : l1_addr;
  assign paddr   = {l2_frame, ofs};  // R4

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rsp_valid,
  input  logic        rsp_ok,
  output walk_state_e state
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: if (start)     state_d = WS_RD1;
      WS_RD1:  if (rsp_valid) state_d = rsp_ok ? WS_RD2 : WS_DONE;
      WS_RD2:  if (rsp_valid) state_d = WS_DONE;
      WS_DONE:                state_d = WS_IDLE;
      default:                state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_L1_BAD_SKIPS_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_RD1 && rsp_valid && !rsp_ok) |=> state_q == WS_DONE); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_DONE) |=> state_q == WS_IDLE); // R10

  AST_L2_AFTER_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_RD2) |-> $past(state_q) inside {WS_RD1, WS_RD2}); // R5

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFS_W = 12,
  parameter int L1_W  = 10,
  parameter int L2_W  = 10,
  parameter int PTE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   walk_start,
  input  logic [VA_W-1:0]        walk_vaddr,
  input  logic [PTE_W-OFS_W-1:0] root_frame,
  output logic                   walk_ready,
  output logic                   mem_rd_valid,
  output logic [PTE_W-1:0]       mem_rd_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  output logic                   done_valid,
  output logic                   done_fault,
  output logic                   done_level,
  output logic [PTE_W-1:0]       done_paddr,
  output logic [PTE_W-1:0]       done_entry
);

  localparam int FRAME_W = PTE_W - OFS_W;

  logic        rst_ns;
  walk_state_e state;

  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] l1_q;
  logic               fault_q, level_q;
  logic [PTE_W-1:0]   paddr_q, entry_q;

  logic               accept, ld_l1, ld_res;
  logic               rsp_ok;
  logic [PTE_W-1:0]   gen_addr, gen_paddr;

  pt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign rsp_ok = mem_rsp_data[0];

  pt_walk_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .start     (walk_start),
    .rsp_valid (mem_rsp_valid),
    .rsp_ok    (rsp_ok),
    .state     (state)
  );

  pt_addr_gen #(
    .VA_W (VA_W), .OFS_W (OFS_W), .L1_W (L1_W), .L2_W (L2_W), .PTE_W (PTE_W)
  ) u_addr (
    .vaddr      (va_q),
    .root_frame (root_q),
    .l1_frame   (l1_q),
    .l2_frame   (mem_rsp_data[PTE_W-1:OFS_W]),
    .sel_l2     (state == WS_RD2),
    .rd_addr    (gen_addr),
    .paddr      (gen_paddr)
  );

  // clock enables
  assign accept = (state == WS_IDLE) && walk_start;
  assign ld_l1  = (state == WS_RD1) && mem_rsp_valid && rsp_ok;
  assign ld_res = mem_rsp_valid &&
                  (((state == WS_RD1) && !rsp_ok) || (state == WS_RD2));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      va_q   <= '0;
      root_q <= '0;
    end else if (accept) begin
      va_q   <= walk_vaddr;
      root_q <= root_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    l1_q <= '0;
    else if (ld_l1) l1_q <= mem_rsp_data[PTE_W-1:OFS_W];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      fault_q <= 1'b0;
      level_q <= 1'b0;
      paddr_q <= '0;
      entry_q <= '0;
    end else if (ld_res) begin
      fault_q <= !rsp_ok;
      level_q <= (state == WS_RD2);
      paddr_q <= rsp_ok ? gen_paddr : '0;
      entry_q <= mem_rsp_data;
    end
  end

  assign walk_ready   = (state == WS_IDLE);
  assign mem_rd_valid = (state == WS_RD1) || (state == WS_RD2);
  assign mem_rd_addr  = gen_addr;
  assign done_valid   = (state == WS_DONE);
  assign done_fault   = fault_q;
  assign done_level   = level_q;
  assign done_paddr   = paddr_q;
  assign done_entry   = entry_q;

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R9

  AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_valid && !done_fault) |-> done_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]); // R4

  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    (done_valid && done_fault) |-> done_paddr == '0); // R7

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    walk_ready |-> (!mem_rd_valid && !done_valid)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    done_valid |=> (!done_valid && walk_ready)); // R10

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] ROOT = 20'h00100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        walk_start;
  logic [31:0] walk_vaddr;
  logic [19:0] root_frame;
  logic        walk_ready, mem_rd_valid, done_valid, done_fault, done_level;
  logic [31:0] mem_rd_addr, done_paddr, done_entry;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int checks = 0, errors = 0;
  int cyc = 0;
  int mem_lat = 0, wcnt = 0, nreads = 0, last_rsp_cyc = 0;
  logic [31:0] rd_log [0:3];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pt_walker dut (
    .clk (clk), .rst_n (rst_n), .walk_start (walk_start), .walk_vaddr (walk_vaddr),
    .root_frame (root_frame), .walk_ready (walk_ready), .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr (mem_rd_addr), .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
    .done_valid (done_valid), .done_fault (done_fault), .done_level (done_level),
    .done_paddr (done_paddr), .done_entry (done_entry)
  );

  // Entry contents derived from the address alone; bits [11:1] carry junk
  function automatic logic [31:0] memf(input logic [31:0] a);
    int i1, i2;
    logic [19:0] fr;
    if (a[31:12] == ROOT) begin
      i1 = int'(a[11:2]);
      return {20'h00200 + 20'(i1), 11'h2AA, 1'((i1 % 5) != 3)};
    end else if (a[31:12] >= 20'h00200 && a[31:12] < 20'h00600) begin
      i1 = int'(a[31:12]) - 'h200;
      i2 = int'(a[11:2]);
      fr = 20'(i1 * 1024 + i2) ^ 20'hA5C3E;
      return {fr, 11'h555, 1'(((i1 + i2) % 7) != 0)};
    end
    return 32'hDEADBEE0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      wcnt = 0;
    end else if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
    end else if (mem_rd_valid) begin
      if (wcnt >= mem_lat) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memf(mem_rd_addr);
        if (nreads < 4) rd_log[nreads] = mem_rd_addr;
        nreads++;
        last_rsp_cyc = cyc;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_walk(input int i1, input int i2, input int ofs, input bit hold);
    logic [31:0] va, l1a, l2a, e1, e2, xpa, xent;
    bit xf, xl;
    int xn, t;
    va = {10'(i1), 10'(i2), 12'(ofs)};        // R1 field layout
    l1a = {ROOT, 12'h000} + 32'(i1 * 4);      // R2
    e1 = memf(l1a);
    l2a = {e1[31:12], 12'h000} + 32'(i2 * 4); // R3
    e2 = memf(l2a);
    if (!e1[0]) begin xf = 1; xl = 0; xn = 1; xent = e1; xpa = 0; end
    else if (!e2[0]) begin xf = 1; xl = 1; xn = 2; xent = e2; xpa = 0; end
    else begin xf = 0; xl = 0; xn = 2; xent = e2; xpa = {e2[31:12], va[11:0]}; end

    @(negedge clk);
    nreads = 0;
    walk_vaddr = va;
    walk_start = 1'b1;
    @(negedge clk);
    chk(walk_ready == 1'b0, "R8 ready low while busy", 32'(walk_ready), 32'h0);
    if (hold) walk_vaddr = ~va;   // R8: start kept high with another address
    else walk_start = 1'b0;
    t = 0;
    while (!done_valid && t < 200) begin @(negedge clk); t++; end
    walk_start = 1'b0;
    chk(done_valid == 1'b1, "R9 walk completes", 32'(done_valid), 32'h1);
    chk(cyc == last_rsp_cyc + 1, "R10 done one cycle after response", 32'(cyc), 32'(last_rsp_cyc + 1));
    chk(nreads == xn, xf ? (xl ? "R7 read count" : "R6 read count") : "R5 read count",
        32'(nreads), 32'(xn));
    chk(rd_log[0] == l1a, "R2 first-level address", rd_log[0], l1a);
    if (xn == 2) chk(rd_log[1] == l2a, "R3 second-level address", rd_log[1], l2a);
    chk(done_fault == xf, "R6 R7 fault flag", 32'(done_fault), 32'(xf));
    if (xf) chk(done_level == xl, xl ? "R7 fault level" : "R6 fault level", 32'(done_level), 32'(xl));
    chk(done_paddr == xpa, "R4 physical address", done_paddr, xpa);
    chk(done_entry == xent, "R4 returned entry", done_entry, xent);
    @(negedge clk);
    chk(done_valid == 1'b0 && walk_ready == 1'b1, "R10 pulse then ready",
        {30'h0, done_valid, walk_ready}, 32'h1);
    chk(nreads == xn, "R8 no extra reads from held start", 32'(nreads), 32'(xn));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    walk_start = 1'b0;
    walk_vaddr = '0;
    root_frame = ROOT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(walk_ready == 1'b1, "R11 ready after reset", 32'(walk_ready), 32'h1);
    chk(mem_rd_valid == 1'b0, "R11 no read after reset", 32'(mem_rd_valid), 32'h0);
    chk(done_valid == 1'b0, "R11 no done after reset", 32'(done_valid), 32'h0);

    for (int i1 = 0; i1 < 1024; i1 += 31) begin
      for (int k = 0; k < 4; k++) begin
        int i2;
        i2 = (k == 0) ? 0 : (k == 1) ? 1023 : (k == 2) ? 511 : (i1 * 13 + 5) % 1024;
        mem_lat = (i1 + k) % 4;
        do_walk(i1, i2, (i1 * 7 + i2 * 3) % 4096, (k == 3));
      end
    end
    mem_lat = 2;
    do_walk(1023, 1023, 4095, 1'b0);
    do_walk(1023, 0, 0, 1'b1);
    mem_lat = 0;
    do_walk(3, 7, 12'h123, 1'b0);   // first-level fault (3 mod 5 == 3), R6
    do_walk(0, 7, 12'hABC, 1'b0);   // second-level fault ((0+7) mod 7 == 0), R7

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule